// File: doc/BRIEF.md
# Byte-Wide Two-Wire Serial Memory Master

This block lets a processor move single bytes to and from an external serial memory over a two-wire bus (clock plus open-drain data). Software works through a data register and a command port. To send a byte, it loads the data register and then writes the send code. To fetch a byte, it writes the fetch code, and the byte shows up in the data register once the transfer ends. A busy flag covers the whole transfer. A one-cycle interrupt pulse marks the cycle in which busy drops. After a send, an acknowledge flag tells software whether the memory answered.

The bus clock is made by dividing the system clock. The half period is `HALF = ceil(CLK_HZ / (2 * SCL_HZ))` system cycles, so the bus rate is at or just below the 78 kHz target. The clock toggles only during a transfer and rests high otherwise. A transfer is nine bus clocks: eight data bits, most significant first, then one acknowledge slot. The block takes over the two shared pins only while its pin-enable input is 1.

Top module: `twm_master`

## Requirements
- R1: Out of reset: busy, irq, rxAck and dataOut are 0, sclOut is 1, and sdaPullLow is 0.
- R2: With busy low and pinEnable 1, a cmdWe pulse with cmd = 4'h1 (send) or 4'h2 (fetch) starts a transfer. busy rises at the next clock edge and stays high for exactly 18*HALF cycles.
- R3: During a transfer, sclOut gives nine bus clocks. Each one is HALF cycles low followed by HALF cycles high, starting with a low phase. Whenever busy is low, sclOut is 1.
- R4: In a send, data bit 7-b is put on SDA for bus clock b (b = 0..7), most significant bit first. It appears one system cycle after sclOut falls, so SDA never changes while sclOut is high. A 0 bit pulls the line low and a 1 bit releases it; the block never drives the line high.
- R5: In the ninth bus clock of a send, SDA is released. rxAck is updated from SDA as sampled at the last cycle of that clock's high phase: 1 when the line is low, 0 when it is high. rxAck then holds until the next send completes.
- R6: In a fetch, SDA is released for all nine bus clocks. SDA is sampled at the last cycle of each high phase, and the first sample is stored as the most significant bit. The eight data bits appear on dataOut in the cycle busy falls.
- R7: irq is high for exactly one cycle, the first cycle in which busy is low after a transfer. It is low at all other times.
- R8: A command written while busy is high is ignored. A cmd value other than 4'h1 or 4'h2 is ignored. A dataWe write while busy is high is ignored. When busy is low, dataWe loads dataIn into the data register at the next edge.
- R9: While pinEnable is 0, sclOe and sdaPullLow are 0 and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinEnable | input | 1 | Hands the two bus pins to the block when 1 |
| dataWe | input | 1 | Data register write strobe |
| dataIn | input | 8 | Byte to load into the data register |
| cmdWe | input | 1 | Command write strobe |
| cmd | input | 4 | Command code: 4'h1 send, 4'h2 fetch |
| dataOut | output | 8 | Data register contents |
| busy | output | 1 | High while a transfer runs |
| irq | output | 1 | One-cycle pulse at transfer end |
| rxAck | output | 1 | 1 if the last send was acknowledged |
| sclOut | output | 1 | Bus clock level |
| sclOe | output | 1 | Bus clock output enable |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | Pulls the bus data line low when 1 |

## Verification
A wrong phase counter or bit index shows up at once as a shifted edge on sclOut or a wrong busy length. The per-cycle comparison catches this in the first bus clock where it goes wrong. A fault in the shift register shows as a wrong SDA level within one bus clock during a send, but during a fetch it shows only on dataOut when busy falls, up to 18*HALF cycles later. Faults in the acknowledge capture or in the ignore rules for commands and data writes show on rxAck, dataOut or busy within a cycle of the stimulus or of the transfer end.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int DATA_W        = 8;
  localparam int CMD_W         = 4;
  localparam int BITS_PER_XFER = DATA_W + 1;

  localparam logic [CMD_W-1:0] CMD_SEND  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_FETCH = 4'h2;

  typedef struct packed {
    logic load;     // copy data register into shifter
    logic updSda;   // present next SDA level
    logic sample;   // capture SDA at end of high phase
    logic finish;   // last sample of the transfer
    logic ackBit;   // current bit is the acknowledge slot
    logic txMode;   // transfer is a send
  } strobe_t;
endpackage

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cmdWe,
  input  logic [CMD_W-1:0] cmd,
  output strobe_t          stb,
  output logic             busy,
  output logic             irq,
  output logic             scl
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(BITS_PER_XFER);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;

  state_t           state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             txMode;

  logic phaseEnd, lastBit, accept, validCmd;

  assign phaseEnd = (phaseCnt == CNT_W'(HALF - 1));
  assign lastBit  = (bitIdx == BIT_W'(BITS_PER_XFER - 1));
  assign validCmd = (cmd == CMD_SEND) || (cmd == CMD_FETCH);
  assign accept   = (state == ST_IDLE) && enable && cmdWe && validCmd;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb        = '0;
    stb.load   = accept;
    stb.updSda = (state == ST_LOW) && (phaseCnt == '0);
    stb.sample = (state == ST_HIGH) && phaseEnd;
    stb.finish = stb.sample && lastBit;
    stb.ackBit = lastBit;
    stb.txMode = txMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      txMode   <= 1'b0;
      scl      <= 1'b1;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
            bitIdx   <= '0;
            txMode   <= (cmd == CMD_SEND);
            scl      <= 1'b0;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= '0;
            scl      <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (lastBit) begin
              state <= ST_IDLE;
              irq   <= 1'b1;
            end else begin
              state  <= ST_LOW;
              bitIdx <= bitIdx + 1'b1;
              scl    <= 1'b0;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the end pulse comes only in the first idle cycle after a transfer
  p_irq_at_busy_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!busy && $past(busy)));

  // R3: the bus clock rests high whenever no transfer runs
  p_scl_parked_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> scl);

  // R2: the phase counter never passes the half period
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= CNT_W'(HALF - 1));
endmodule

// File: rtl/twm_dp.sv
module twm_dp
  import twm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              busy,
  input  logic              sclLevel,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] dataReg,
  output logic              rxAck,
  output logic              sdaLow
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
      rxAck    <= 1'b0;
      sdaLow   <= 1'b0;
    end else begin
      if (dataWe && !busy) dataReg <= dataIn;
      if (stb.load) shiftReg <= dataReg;
      if (stb.updSda) sdaLow <= stb.txMode && !stb.ackBit && !shiftReg[DATA_W-1];
      if (stb.sample && !stb.ackBit) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (stb.finish) begin
        sdaLow <= 1'b0;
        if (stb.txMode) rxAck <= !sdaIn;
        else            dataReg <= shiftReg;
      end
    end
  end

  // R4: SDA holds its level for as long as the bus clock stays high
  p_sda_still_high_scl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel)) |-> $stable(sdaLow));

  // R8: the data register is frozen while a transfer runs
  p_data_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dataReg));
endmodule

// File: rtl/twm_master.sv
module twm_master
  import twm_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int SCL_HZ = 78_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinEnable,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cmdWe,
  input  logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy,
  output logic              irq,
  output logic              rxAck,
  output logic              sclOut,
  output logic              sclOe,
  input  logic              sdaIn,
  output logic              sdaPullLow
);
  localparam int HALF_RAW = (CLK_HZ + 2 * SCL_HZ - 1) / (2 * SCL_HZ);
  localparam int HALF     = (HALF_RAW < 2) ? 2 : HALF_RAW;

  strobe_t stb;
  logic    sclLevel, sdaLow;

  twm_ctrl #(.HALF(HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(pinEnable), .cmdWe(cmdWe), .cmd(cmd),
    .stb(stb), .busy(busy), .irq(irq), .scl(sclLevel)
  );

  twm_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .sclLevel(sclLevel),
    .dataWe(dataWe), .dataIn(dataIn), .sdaIn(sdaIn),
    .dataReg(dataOut), .rxAck(rxAck), .sdaLow(sdaLow)
  );

  assign sclOut     = sclLevel;
  assign sclOe      = pinEnable;
  assign sdaPullLow = sdaLow && pinEnable;

  // R9: with the pins handed back, the data line is never pulled
  p_pins_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pinEnable |-> (!sdaPullLow && !sclOe));
endmodule

// File: tb/twm_master_bench.sv
`timescale 1ns/1ps
module twm_master_bench;
  localparam int H = 4;          // 624 kHz / (2 * 78 kHz)
  localparam int T = 18 * H;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinEnable = 1'b1;
  logic dataWe = 1'b0;
  logic [7:0] dataIn = '0;
  logic cmdWe = 1'b0;
  logic [3:0] cmd = '0;
  logic [7:0] dataOut;
  logic busy, irq, rxAck, sclOut, sclOe, sdaIn, sdaPullLow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // slave and model state
  logic [7:0] slaveByte = 8'h00;
  logic       slaveAck = 1'b0;
  int  e = 0;
  bit  act = 0;
  bit  mTx = 0;
  logic [7:0] mByte = '0, mData = '0;
  bit  mAck = 0;
  logic slaveLow;

  always #2.5 clk = ~clk;

  twm_master #(.CLK_HZ(624_000), .SCL_HZ(78_000)) u_twm_master (
    .clk(clk), .rstN(rstN), .pinEnable(pinEnable), .dataWe(dataWe), .dataIn(dataIn),
    .cmdWe(cmdWe), .cmd(cmd), .dataOut(dataOut), .busy(busy), .irq(irq), .rxAck(rxAck),
    .sclOut(sclOut), .sclOe(sclOe), .sdaIn(sdaIn), .sdaPullLow(sdaPullLow)
  );

  always_comb begin
    slaveLow = 1'b0;
    if (act && e < T) begin
      if (e / (2 * H) < 8) slaveLow = !mTx && !slaveByte[7 - e / (2 * H)];
      else                 slaveLow = mTx && slaveAck;
    end
  end
  assign sdaIn = !(sdaPullLow || slaveLow);

  function automatic bit expBusy();
    return act && e < T;
  endfunction

  function automatic bit expScl();
    if (!(act && e < T)) return 1'b1;
    return ((e / H) % 2) == 1;
  endfunction

  function automatic bit expSda();
    int b;
    if (!(act && e < T) || !pinEnable) return 1'b0;
    b = (e % (2 * H) >= 1) ? e / (2 * H) : e / (2 * H) - 1;
    if (b < 0 || b >= 8) return 1'b0;
    return mTx && !mByte[7 - b];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      act <= 0; e <= 0; mTx <= 0; mByte <= '0; mData <= '0; mAck <= 0;
    end else begin
      if (act && e == T - 1) begin
        if (mTx) mAck <= slaveAck;
        else     mData <= slaveByte;
      end
      if (dataWe && !expBusy()) mData <= dataIn;
      if (!expBusy() && cmdWe && pinEnable && (cmd == 4'h1 || cmd == 4'h2)) begin
        act <= 1; e <= 0; mTx <= (cmd == 4'h1); mByte <= mData;
      end else if (act) begin
        if (e == T) act <= 0;
        else        e <= e + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act_v, exp_v);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == expBusy(), "R2 busy", busy, expBusy());
      chk(irq == (act && e == T), "R7 irq", irq, act && e == T);
      chk(sclOut == expScl(), "R3 scl", sclOut, expScl());
      chk(sdaPullLow == expSda(), "R4 sda", sdaPullLow, expSda());
      chk(rxAck == mAck, "R5 rxAck", rxAck, mAck);
      chk(dataOut == mData, "R6 dataOut", dataOut, mData);
      chk(sclOe == pinEnable, "R9 sclOe", sclOe, pinEnable);
    end
    if (cyc >= LIMIT) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic writeData(input logic [7:0] v);
    @(negedge clk); dataWe = 1'b1; dataIn = v;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic issue(input logic [3:0] c);
    @(negedge clk); cmdWe = 1'b1; cmd = c;
    @(negedge clk); cmdWe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit ack);
    slaveAck = ack;
    writeData(v);
    issue(4'h1);
    waitIdle();
    chk(rxAck == ack, "R5 ack after send", rxAck, ack);
  endtask

  task automatic fetchByte(input logic [7:0] v);
    slaveByte = v;
    issue(4'h2);
    waitIdle();
    chk(dataOut == v, "R6 fetched byte", dataOut, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && irq == 0 && rxAck == 0 && dataOut == 0, "R1 reset flags",
        {busy, irq, rxAck, dataOut}, 0);
    chk(sclOut == 1 && sdaPullLow == 0, "R1 reset pins", {sclOut, sdaPullLow}, 2);
    rstN = 1'b1;
    @(negedge clk);

    sendByte(8'hA5, 1);
    sendByte(8'h3C, 0);
    sendByte(8'h80, 1);
    fetchByte(8'h96);
    fetchByte(8'h00);
    fetchByte(8'hFF);

    // R8: command and data write while busy are ignored
    slaveByte = 8'h5A;
    writeData(8'h11);
    issue(4'h1);
    @(negedge clk); dataWe = 1'b1; dataIn = 8'hEE; cmdWe = 1'b1; cmd = 4'h2;
    @(negedge clk); dataWe = 1'b0; cmdWe = 1'b0;
    chk(dataOut == 8'h11, "R8 data write while busy", dataOut, 8'h11);
    waitIdle();
    chk(busy == 0, "R8 no extra transfer", busy, 0);

    // R8: unknown code ignored
    issue(4'h7);
    chk(busy == 0, "R8 unknown code", busy, 0);

    // R9: pins disabled, command ignored
    pinEnable = 1'b0;
    issue(4'h1);
    chk(busy == 0 && sclOe == 0 && sdaPullLow == 0, "R9 disabled", {busy, sclOe, sdaPullLow}, 0);
    pinEnable = 1'b1;

    // R7/R2: back-to-back command in the irq cycle is accepted
    slaveAck = 1;
    writeData(8'h69);
    issue(4'h1);
    while (!irq) @(negedge clk);
    cmdWe = 1'b1; cmd = 4'h1;
    @(negedge clk); cmdWe = 1'b0;
    chk(busy == 1, "R2 accept in irq cycle", busy, 1);
    waitIdle();

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule